// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Enable

This block sits between a set of peripheral event sources and a small CPU core. Each source raises a one-cycle pulse. The pulse latches into a pending flag, and the flag stays set until it is cleared. A mask register chooses which pending flags may interrupt. A global enable bit gates the request as a whole.

When a source is both pending and unmasked and the global enable is on, the controller raises a request. It also gives the index of the winning source as the vector number. When the CPU reports that it has taken the vector, the controller drops the global enable and clears that source's flag. A return-from-interrupt strobe turns the global enable back on. Software can also set the enable inside a handler to allow nesting. Software clears flags by writing ones to their bit positions. A peripheral event that arrives in the same cycle as a clear is never lost.

Top module: `vic_top`

## Requirements
- R1: After reset, all pending flags are 0, the mask is 0, the global enable is 0, `irq_o` is 0 and `vec_o` is 0.
- R2: A 1 on `irq_pulse_i[i]` sets pending flag i from the next cycle on. The flag then holds until it is cleared.
- R3: When `wr_mask_i` is 1, the mask register loads `wdata_i` on the next cycle. Mask bit i set to 1 enables source i.
- R4: `irq_o` is 1 exactly when the global enable is 1 and at least one flag is both pending and unmasked.
- R5: `vec_o` gives the lowest index among the flags that are pending and unmasked. It is 0 when there is no such flag. It does not depend on the global enable.
- R6: `vec_ack_i` is honoured only in a cycle where `irq_o` is 1. In the next cycle the global enable is 0 and the flag at the acknowledged `vec_o` is cleared. In a cycle where `irq_o` is 0, an acknowledge changes no flag and does not change the enable.
- R7: `reti_i` sets the global enable to 1 on the next cycle. An honoured acknowledge in the same cycle takes precedence and leaves the enable at 0.
- R8: When `wr_gie_i` is 1, the global enable loads `gie_wdata_i`. This write has the lowest priority: an honoured acknowledge and `reti_i` both override it.
- R9: When `wr_flag_i` is 1, every flag whose `wdata_i` bit is 1 is cleared. Flags whose `wdata_i` bit is 0 are left unchanged.
- R10: A peripheral pulse in the same cycle as a clear of that flag leaves the flag set. This holds for a software clear and for an acknowledge clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pulse_i | input | NUM_SRC | One-cycle event pulses from the peripherals |
| wr_mask_i | input | 1 | Strobe that loads the mask register from `wdata_i` |
| wr_flag_i | input | 1 | Strobe that clears the flags where `wdata_i` is 1 |
| wdata_i | input | NUM_SRC | Write data for the mask and flag strobes |
| wr_gie_i | input | 1 | Strobe that writes the global enable |
| gie_wdata_i | input | 1 | Value for the global enable write |
| vec_ack_i | input | 1 | CPU has taken the vector shown on `vec_o` |
| reti_i | input | 1 | CPU executed a return from interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | $clog2(NUM_SRC) | Index of the winning source |
| flags_o | output | NUM_SRC | Pending flags, readable |
| mask_o | output | NUM_SRC | Mask register, readable |
| gie_o | output | 1 | Global enable bit |

## Verification
The arbitration is driven with several pending patterns: two sources pending at once, a single high-index source, and sources 0 and 1 together. These show whether the lowest-index rule picks correctly across the whole width, and that masking removes a source from the contest. The enable path is driven with each pair of strobes that can collide: acknowledge with return, return with software write, acknowledge while no request is raised. These show the priority order and that an acknowledge with no request is ignored. The flag path combines pulses with write-one clears and with acknowledge clears, and also writes zeros. This separates "pulse wins" from "clear wins" and from "clear touches other bits".

// File: rtl/vic_pkg.sv
package vic_pkg;

    // Strobes that act on the global enable bit
    typedef struct packed {
        logic ack;      // honoured vector acknowledge
        logic reti;     // return from interrupt
        logic wr_gie;   // software write strobe
        logic gie_val;  // software write value
    } gie_req_t;

endpackage

// File: rtl/vic_flags.sv
module vic_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // a new event overrides any clear in the same cycle
        st_d.flags = (st_q.flags & ~clr_i) | pulse_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R10 / R2: a pulse always lands
        a_r10_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_i[g] |=> flags_o[g]);
        // R2: a flag holds without a clear
        a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
        // R9: a clear with no pulse empties the bit
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !pulse_i[g]) |=> !flags_o[g]);
    end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask_i,
    input  logic [N-1:0] mask_wdata_i,
    input  gie_req_t     req_i,
    output logic [N-1:0] mask_o,
    output logic         gie_o
);

    typedef struct packed {
        logic [N-1:0] mask;
        logic         gie;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask_i) st_d.mask = mask_wdata_i;
        // priority: acknowledge, then return, then software write
        if (req_i.ack)         st_d.gie = 1'b0;
        else if (req_i.reti)   st_d.gie = 1'b1;
        else if (req_i.wr_gie) st_d.gie = req_i.gie_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign gie_o  = st_q.gie;

    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_o == $past(mask_wdata_i)));
    a_r6_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
        req_i.ack |=> !gie_o);
    a_r7_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i.reti && !req_i.ack) |=> gie_o);
    a_r8_gie_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i.ack && !req_i.reti && !req_i.wr_gie) |=> $stable(gie_o));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_i,
    input  logic             gie_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] vec_o
);

    // below[i] is 1 when some lower index is also active
    logic [N-1:0] below;
    logic [N-1:0] win;

    assign below[0] = 1'b0;
    for (genvar g = 1; g < N; g++) begin : g_chain
        assign below[g] = below[g-1] | pend_i[g-1];
    end
    assign win = pend_i & ~below;

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) vec_o = IDX_W'(i);
        end
    end

    assign irq_o = gie_i & (|pend_i);

    a_r5_onehot_win: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));
    a_r5_vec_active: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_i) |-> pend_i[vec_o]);
    a_r5_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ((N'(1) << vec_o) - N'(1))) == '0));

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pulse_i,
    input  logic               wr_mask_i,
    input  logic               wr_flag_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic               wr_gie_i,
    input  logic               gie_wdata_i,
    input  logic               vec_ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [IDX_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0] flags_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               gie_o
);

    logic               ack_ok;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;
    gie_req_t           req;

    assign ack_ok = vec_ack_i & irq_o;
    assign clr    = (wr_flag_i ? wdata_i : '0)
                  | (ack_ok ? (NUM_SRC'(1) << vec_o) : '0);
    assign pend   = flags_o & mask_o;

    assign req.ack     = ack_ok;
    assign req.reti    = reti_i;
    assign req.wr_gie  = wr_gie_i;
    assign req.gie_val = gie_wdata_i;

    vic_flags #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (irq_pulse_i),
        .clr_i   (clr),
        .flags_o (flags_o)
    );

    vic_ctrl #(.N(NUM_SRC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_mask_i    (wr_mask_i),
        .mask_wdata_i (wdata_i),
        .req_i        (req),
        .mask_o       (mask_o),
        .gie_o        (gie_o)
    );

    vic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .gie_i  (gie_o),
        .irq_o  (irq_o),
        .vec_o  (vec_o)
    );

    // R6: the serviced flag is gone unless a fresh pulse hit it
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> (flags_o[$past(vec_o)] == $past(irq_pulse_i[vec_o])));
    // R6: an acknowledge with no request leaves the enable alone
    a_r6_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack_i && !irq_o && !reti_i && !wr_gie_i) |=> $stable(gie_o));
    // R4: a request implies enable and an unmasked pending source
    a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_o && flags_o[vec_o] && mask_o[vec_o]));

endmodule

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_pulse_i = '0;
    logic         wr_mask_i = 1'b0;
    logic         wr_flag_i = 1'b0;
    logic [N-1:0] wdata_i = '0;
    logic         wr_gie_i = 1'b0;
    logic         gie_wdata_i = 1'b0;
    logic         vec_ack_i = 1'b0;
    logic         reti_i = 1'b0;
    logic         irq_o;
    logic [2:0]   vec_o;
    logic [N-1:0] flags_o;
    logic [N-1:0] mask_o;
    logic         gie_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vic_top #(.NUM_SRC(N)) i_vic_top (
        .clk(clk), .rst_n(rst_n), .irq_pulse_i(irq_pulse_i),
        .wr_mask_i(wr_mask_i), .wr_flag_i(wr_flag_i), .wdata_i(wdata_i),
        .wr_gie_i(wr_gie_i), .gie_wdata_i(gie_wdata_i),
        .vec_ack_i(vec_ack_i), .reti_i(reti_i), .irq_o(irq_o),
        .vec_o(vec_o), .flags_o(flags_o), .mask_o(mask_o), .gie_o(gie_o)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] pulse;
        logic       wm;
        logic       wf;
        logic       wg;
        logic       gv;
        logic [7:0] wd;
        logic       ack;
        logic       reti;
        logic [7:0] ef;
        logic [7:0] em;
        logic       eg;
        logic       ei;
        logic [2:0] ev;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        //  req  pulse wm wf wg gv wd   ack reti  flags mask  gie irq vec
        '{4'd2,  8'h24,0,0,0,0,8'h00,0,0, 8'h24,8'h00,0,0,3'd0}, // R2
        '{4'd3,  8'h00,1,0,0,0,8'hFF,0,0, 8'h24,8'hFF,0,0,3'd2}, // R3 R5
        '{4'd8,  8'h00,0,0,1,1,8'h00,0,0, 8'h24,8'hFF,1,1,3'd2}, // R8 R4
        '{4'd6,  8'h00,0,0,0,0,8'h00,1,0, 8'h20,8'hFF,0,0,3'd5}, // R6
        '{4'd7,  8'h00,0,0,0,0,8'h00,0,1, 8'h20,8'hFF,1,1,3'd5}, // R7
        '{4'd3,  8'h00,1,0,0,0,8'hDF,0,0, 8'h20,8'hDF,1,0,3'd0}, // R3 R4
        '{4'd5,  8'h80,0,0,0,0,8'h00,0,0, 8'hA0,8'hDF,1,1,3'd7}, // R5
        '{4'd9,  8'h00,0,1,0,0,8'h20,0,0, 8'h80,8'hDF,1,1,3'd7}, // R9
        '{4'd10, 8'h80,0,1,0,0,8'h80,0,0, 8'h80,8'hDF,1,1,3'd7}, // R10
        '{4'd10, 8'h80,0,0,0,0,8'h00,1,0, 8'h80,8'hDF,0,0,3'd7}, // R10 R6
        '{4'd6,  8'h00,0,0,0,0,8'h00,1,0, 8'h80,8'hDF,0,0,3'd7}, // R6 ignored
        '{4'd8,  8'h00,0,0,1,0,8'h00,0,1, 8'h80,8'hDF,1,1,3'd7}, // R8 reti wins
        '{4'd7,  8'h00,0,0,0,0,8'h00,1,1, 8'h00,8'hDF,0,0,3'd0}, // R7 ack wins
        '{4'd5,  8'h03,0,0,0,0,8'h00,0,0, 8'h03,8'hDF,0,0,3'd0}, // R5
        '{4'd4,  8'h00,0,0,1,1,8'h00,0,0, 8'h03,8'hDF,1,1,3'd0}, // R4
        '{4'd9,  8'h00,0,1,0,0,8'h01,0,0, 8'h02,8'hDF,1,1,3'd1}, // R9
        '{4'd9,  8'h00,0,1,0,0,8'h00,0,0, 8'h02,8'hDF,1,1,3'd1}  // R9 zeros
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [7:0] ef,
                             input logic [7:0] em, input logic eg,
                             input logic ei, input logic [2:0] ev);
        check(req, "outputs", {flags_o, mask_o, gie_o, irq_o, vec_o},
              {ef, em, eg, ei, ev});
    endtask

    task automatic idle();
        irq_pulse_i = '0; wr_mask_i = 0; wr_flag_i = 0; wdata_i = '0;
        wr_gie_i = 0; gie_wdata_i = 0; vec_ack_i = 0; reti_i = 0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all(1, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            irq_pulse_i = TBL[k].pulse; wr_mask_i = TBL[k].wm;
            wr_flag_i = TBL[k].wf; wr_gie_i = TBL[k].wg;
            gie_wdata_i = TBL[k].gv; wdata_i = TBL[k].wd;
            vec_ack_i = TBL[k].ack; reti_i = TBL[k].reti;
            @(negedge clk);
            check_all(int'(TBL[k].req), TBL[k].ef, TBL[k].em,
                      TBL[k].eg, TBL[k].ei, TBL[k].ev);
            idle();
        end
        // R2: flags hold over idle cycles
        repeat (4) @(negedge clk);
        check(2, "hold", {24'h0, flags_o}, 32'h02);
        // R10: ack clear collides with pulse on the served source (vec 1)
        irq_pulse_i = 8'h02; vec_ack_i = 1;
        @(negedge clk);
        check(10, "ack+pulse flags", {24'h0, flags_o}, 32'h02);
        check(6, "ack gie", {31'h0, gie_o}, 32'h0);
        idle();
        // R1: mid-run reset returns everything to zero
        irq_pulse_i = 8'hFF; wr_mask_i = 1; wdata_i = 8'hFF;
        wr_gie_i = 1; gie_wdata_i = 1; rst_n = 0;
        @(negedge clk);
        idle();
        check_all(1, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0);
        rst_n = 1;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule